// File: doc/BRIEF.md
# Integer Operate Execution Unit

This block is the integer execute stage of a 64-bit processor pipeline. Each cycle it can accept one operate instruction. The instruction arrives as a 6-bit opcode, an 11-bit function field, two source operands given as register index plus value, an optional 8-bit immediate, and a destination index. The block computes the result and registers it, so the result appears one cycle later. The output holds the destination index, the result value, a register-file write enable and an overflow event flag.

The block covers:
- add, subtract and low-half multiply, in both 64-bit (quadword) and 32-bit (longword) forms;
- scaled add and subtract for array subscripts;
- signed and unsigned compares, bitwise logicals and shifts;
- conditional moves.

Longword results are always returned in canonical form, with bit 31 copied into every upper bit. Whether overflow is reported is chosen by each instruction through one bit of its function field. No global mode state is involved.

Register index 31 reads as zero and is never written. The overflow flag is only an event. Delivering a trap is left to the surrounding core.

Top module: `int_op_unit`

## Requirements
- R1: With opcode 0x08, sub-op (function bits 3:0) 0 gives A+B and sub-op 1 gives A−B, as full 64-bit values taken modulo 2^64.
- R2: Longword forms produce a 32-bit result whose bit 31 is copied into bits 63:32. These forms are opcode 0x08 sub-ops 2 (add) and 3 (subtract), and opcode 0x0B sub-op 1 (multiply).
- R3: out_ovf is 1 only when all three of these hold: function bit 10 is set; the operation is opcode 0x08 sub-ops 0–3 or opcode 0x0B; and the signed result does not fit in the operation's width (64 bits for quadword, 32 bits for longword, where the longword sources are the sign-extended low 32 bits). In every other case out_ovf is 0.
- R4: When in_lit_sel is 1, operand B is in_lit zero-extended to 64 bits, and in_rb_val has no effect.
- R5: A source index of 31 reads as zero whatever value is presented. This applies to RA, and to RB when the literal is not selected.
- R6: Opcode 0x08 sub-ops 4–11 are the scaled forms. Let k = sub-op − 4:
  - k bit 0 picks the left shift of A: 0 means shift by 2, 1 means shift by 3;
  - k bit 1 picks the operation: 0 means add B, 1 means subtract B;
  - k bit 2 picks the width: 0 means quadword, 1 means longword in canonical form.
  These forms never raise out_ovf.
- R7: Opcode 0x08 sub-ops 12–15 are compares, giving 1 when the condition holds and 0 otherwise:
  - 12: A equal to B;
  - 13: A less than B, signed;
  - 14: A less than or equal to B, signed;
  - 15: A less than B, unsigned.
- R8: Opcode 0x09 is the logical group:
  - 0: A AND B;
  - 1: A AND NOT B;
  - 2: A OR B;
  - 3: A OR NOT B;
  - 4: A XOR B;
  - 5: A XNOR B.
- R9: Opcode 0x0A is the shift group. Sub-op 0 shifts A left, sub-op 1 shifts A right with zero fill, and sub-op 2 shifts A right with sign fill. The shift amount is bits 5:0 of B.
- R10: Opcode 0x0B sub-op 0 returns the low 64 bits of the signed product A×B.
- R11: Opcode 0x0C sub-ops 0–7 are conditional moves that test A:
  - 0: A = 0;
  - 1: A ≠ 0;
  - 2: A < 0;
  - 3: A ≥ 0;
  - 4: A ≤ 0;
  - 5: A > 0;
  - 6: bit 0 of A set;
  - 7: bit 0 of A clear.
  If the test holds, out_data = B and out_wen = 1. Otherwise out_wen = 0.
- R12: Results appear one cycle after in_valid, and out_valid follows in_valid with the same one-cycle delay. out_wen is 0 in each of these cases: the destination index is 31, the sub-op is unused, or the opcode is unknown. Whenever out_wen is 0, out_data is 0. Synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_opcode | input | 6 | Operation group |
| in_func | input | 11 | Function field: bit 10 is the overflow enable, bits 3:0 are the sub-op |
| in_ra_idx | input | 5 | Index of source A |
| in_ra_val | input | 64 | Value read for source A |
| in_rb_idx | input | 5 | Index of source B |
| in_rb_val | input | 64 | Value read for source B |
| in_lit_sel | input | 1 | Use the literal in place of source B |
| in_lit | input | 8 | Unsigned literal |
| in_rc_idx | input | 5 | Destination index |
| out_valid | output | 1 | Registered result is present |
| out_rc_idx | output | 5 | Destination index of the result |
| out_data | output | 64 | Result value |
| out_wen | output | 1 | Write the result to the register file |
| out_ovf | output | 1 | Enabled overflow occurred |

## Verification
Every operation is run, with the overflow enable both clear and set, against ten operands in all pairings. The operands are zero, one, all-ones, the largest and smallest 64-bit values, the 32-bit sign boundaries placed in 64-bit words, and two mixed patterns.

The boundary pairs separate 64-bit overflow from 32-bit overflow. They show whether longword results copy bit 31 upward, and whether signed compares differ from unsigned ones. They also show that shifts fill with zeros or with the sign bit.

Directed cases apply the literal and the register-31 sources with misleading values on the ignored inputs. Further cases check that destination 31 suppresses the write, and that idle cycles leave out_valid low.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

    localparam int OPC_W    = 6;
    localparam int FUNC_W   = 11;
    localparam int SUBOP_W  = 4;
    localparam int TRAP_BIT = 10;

    localparam logic [OPC_W-1:0] OPC_ARITH = 6'h08;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SHIFT = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_MUL   = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_CMOV  = 6'h0C;

    typedef enum logic [2:0] {
        U_NONE, U_ADD, U_CMP, U_LOG, U_SHF, U_MUL, U_CMOV
    } unit_e;

    typedef enum logic [1:0] { CMP_EQ, CMP_LT, CMP_LE, CMP_ULT } cmp_e;

    typedef enum logic [2:0] {
        LG_AND, LG_BIC, LG_OR, LG_ORN, LG_XOR, LG_EQV
    } log_e;

    typedef enum logic [1:0] { SH_LL, SH_RL, SH_RA } shf_e;

    typedef enum logic [2:0] {
        CM_EQ, CM_NE, CM_LT, CM_GE, CM_LE, CM_GT, CM_LBS, CM_LBC
    } cmc_e;

    typedef struct packed {
        unit_e      unit;
        logic       lw;
        logic       sub;
        logic [1:0] scale;
        logic       trap_ok;
        cmp_e       cmp;
        log_e       lg;
        shf_e       sh;
        cmc_e       cm;
    } ctrl_t;

    typedef struct packed {
        logic valid;
        logic wen;
        logic ovf;
    } stage_flags_t;

    function automatic ctrl_t decode(input logic [OPC_W-1:0]  opc,
                                     input logic [FUNC_W-1:0] func);
        ctrl_t              c;
        logic [SUBOP_W-1:0] s;
        logic [2:0]         k;
        c       = '0;
        c.unit  = U_NONE;
        c.cmp   = CMP_EQ;
        c.lg    = LG_AND;
        c.sh    = SH_LL;
        c.cm    = CM_EQ;
        s       = func[SUBOP_W-1:0];
        k       = 3'(s - 4'd4);
        case (opc)
            OPC_ARITH: begin
                if (s < 4'd4) begin
                    c.unit    = U_ADD;
                    c.sub     = s[0];
                    c.lw      = s[1];
                    c.trap_ok = 1'b1;
                end else if (s < 4'd12) begin
                    c.unit  = U_ADD;
                    c.scale = k[0] ? 2'd3 : 2'd2;
                    c.sub   = k[1];
                    c.lw    = k[2];
                end else begin
                    c.unit = U_CMP;
                    c.cmp  = cmp_e'(s[1:0]);
                end
            end
            OPC_LOGIC: begin
                if (s < 4'd6) begin
                    c.unit = U_LOG;
                    c.lg   = log_e'(s[2:0]);
                end
            end
            OPC_SHIFT: begin
                if (s < 4'd3) begin
                    c.unit = U_SHF;
                    c.sh   = shf_e'(s[1:0]);
                end
            end
            OPC_MUL: begin
                if (s < 4'd2) begin
                    c.unit    = U_MUL;
                    c.lw      = s[0];
                    c.trap_ok = 1'b1;
                end
            end
            OPC_CMOV: begin
                if (!s[3]) begin
                    c.unit = U_CMOV;
                    c.cm   = cmc_e'(s[2:0]);
                end
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic cmov_hit(input cmc_e cm, input logic neg,
                                      input logic zero, input logic lsb);
        logic h;
        case (cm)
            CM_EQ:   h = zero;
            CM_NE:   h = !zero;
            CM_LT:   h = neg;
            CM_GE:   h = !neg;
            CM_LE:   h = neg || zero;
            CM_GT:   h = !neg && !zero;
            CM_LBS:  h = lsb;
            default: h = !lsb;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ieu_opsel.sv
module ieu_opsel #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int LIT_W  = 8
) (
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [RIDX_W-1:0] rb_idx,
    input  logic [XLEN-1:0]   rb_val,
    input  logic              lit_sel,
    input  logic [LIT_W-1:0]  lit,
    output logic [XLEN-1:0]   opa,
    output logic [XLEN-1:0]   opb
);
    localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

    always_comb begin
        opa = (ra_idx == ZERO_IDX) ? '0 : ra_val;
        if (lit_sel)
            opb = {{(XLEN-LIT_W){1'b0}}, lit};
        else if (rb_idx == ZERO_IDX)
            opb = '0;
        else
            opb = rb_val;
    end
endmodule

// File: rtl/ieu_addcmp.sv
module ieu_addcmp #(
    parameter int XLEN = 64
) (
    input  logic              lw,
    input  logic              sub,
    input  logic [1:0]        scale,
    input  logic              is_cmp,
    input  ieu_pkg::cmp_e     cmp,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res,
    output logic              ovf
);
    import ieu_pkg::*;
    localparam int HW = XLEN / 2;

    logic [XLEN-1:0] a_sc, b_eff, sum, add_res, cmp_res;
    logic            ovf_q, ovf_l, hit;

    always_comb begin
        case (scale)
            2'd2:    a_sc = a << 2;
            2'd3:    a_sc = a << 3;
            default: a_sc = a;
        endcase
        b_eff   = sub ? ~b : b;
        sum     = a_sc + b_eff + {{(XLEN-1){1'b0}}, sub};
        ovf_q   = (a_sc[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a_sc[XLEN-1]);
        ovf_l   = (a_sc[HW-1] == b_eff[HW-1]) && (sum[HW-1] != a_sc[HW-1]);
        ovf     = lw ? ovf_l : ovf_q;
        add_res = lw ? {{HW{sum[HW-1]}}, sum[HW-1:0]} : sum;
        case (cmp)
            CMP_EQ:  hit = (a == b);
            CMP_LT:  hit = ($signed(a) < $signed(b));
            CMP_LE:  hit = ($signed(a) <= $signed(b));
            default: hit = (a < b);
        endcase
        cmp_res = {{(XLEN-1){1'b0}}, hit};
        res     = is_cmp ? cmp_res : add_res;
    end
endmodule

// File: rtl/ieu_logshf.sv
module ieu_logshf #(
    parameter int XLEN = 64
) (
    input  logic              is_shift,
    input  ieu_pkg::log_e     lg,
    input  ieu_pkg::shf_e     sh,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res
);
    import ieu_pkg::*;
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] log_res, shf_res;

    always_comb begin
        amt = b[SHW-1:0];
        case (lg)
            LG_AND:  log_res = a & b;
            LG_BIC:  log_res = a & ~b;
            LG_OR:   log_res = a | b;
            LG_ORN:  log_res = a | ~b;
            LG_XOR:  log_res = a ^ b;
            default: log_res = ~(a ^ b);
        endcase
        case (sh)
            SH_LL:   shf_res = a << amt;
            SH_RL:   shf_res = a >> amt;
            default: shf_res = $unsigned($signed(a) >>> amt);
        endcase
        res = is_shift ? shf_res : log_res;
    end
endmodule

// File: rtl/ieu_mul.sv
module ieu_mul #(
    parameter int XLEN = 64
) (
    input  logic              lw,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res,
    output logic              ovf
);
    localparam int HW = XLEN / 2;
    localparam int PW = 2 * XLEN;

    logic [XLEN-1:0] ma, mb;
    logic [PW-1:0]   ea, eb, prod;
    logic [XLEN:0]   hi_q;
    logic [HW:0]     hi_l;

    always_comb begin
        ma   = lw ? {{HW{a[HW-1]}}, a[HW-1:0]} : a;
        mb   = lw ? {{HW{b[HW-1]}}, b[HW-1:0]} : b;
        ea   = {{XLEN{ma[XLEN-1]}}, ma};
        eb   = {{XLEN{mb[XLEN-1]}}, mb};
        prod = ea * eb;
        hi_q = prod[PW-1:XLEN-1];
        hi_l = prod[XLEN-1:HW-1];
        if (lw) begin
            res = {{HW{prod[HW-1]}}, prod[HW-1:0]};
            ovf = !((&hi_l) || !(|hi_l));
        end else begin
            res = prod[XLEN-1:0];
            ovf = !((&hi_q) || !(|hi_q));
        end
    end
endmodule

// File: rtl/int_op_unit.sv
module int_op_unit #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int LIT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [ieu_pkg::OPC_W-1:0]  in_opcode,
    input  logic [ieu_pkg::FUNC_W-1:0] in_func,
    input  logic [RIDX_W-1:0]          in_ra_idx,
    input  logic [XLEN-1:0]            in_ra_val,
    input  logic [RIDX_W-1:0]          in_rb_idx,
    input  logic [XLEN-1:0]            in_rb_val,
    input  logic                       in_lit_sel,
    input  logic [LIT_W-1:0]           in_lit,
    input  logic [RIDX_W-1:0]          in_rc_idx,
    output logic                       out_valid,
    output logic [RIDX_W-1:0]          out_rc_idx,
    output logic [XLEN-1:0]            out_data,
    output logic                       out_wen,
    output logic                       out_ovf
);
    import ieu_pkg::*;
    localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

    ctrl_t           ctrl;
    logic [XLEN-1:0] opa, opb, add_res, ls_res, mul_res, sel_res;
    logic            add_ovf, mul_ovf, raw_ovf, hit, wr_c, ovf_c;
    stage_flags_t    flg_q;
    logic [XLEN-1:0] data_q;
    logic [RIDX_W-1:0] idx_q;

    assign ctrl = decode(in_opcode, in_func);

    ieu_opsel #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LIT_W(LIT_W)) u_opsel (
        .ra_idx (in_ra_idx),
        .ra_val (in_ra_val),
        .rb_idx (in_rb_idx),
        .rb_val (in_rb_val),
        .lit_sel(in_lit_sel),
        .lit    (in_lit),
        .opa    (opa),
        .opb    (opb)
    );

    ieu_addcmp #(.XLEN(XLEN)) u_addcmp (
        .lw    (ctrl.lw),
        .sub   (ctrl.sub),
        .scale (ctrl.scale),
        .is_cmp(ctrl.unit == U_CMP),
        .cmp   (ctrl.cmp),
        .a     (opa),
        .b     (opb),
        .res   (add_res),
        .ovf   (add_ovf)
    );

    ieu_logshf #(.XLEN(XLEN)) u_logshf (
        .is_shift(ctrl.unit == U_SHF),
        .lg      (ctrl.lg),
        .sh      (ctrl.sh),
        .a       (opa),
        .b       (opb),
        .res     (ls_res)
    );

    ieu_mul #(.XLEN(XLEN)) u_mul (
        .lw (ctrl.lw),
        .a  (opa),
        .b  (opb),
        .res(mul_res),
        .ovf(mul_ovf)
    );

    always_comb begin
        hit = cmov_hit(ctrl.cm, opa[XLEN-1], (opa == '0), opa[0]);
        case (ctrl.unit)
            U_ADD, U_CMP: sel_res = add_res;
            U_LOG, U_SHF: sel_res = ls_res;
            U_MUL:        sel_res = mul_res;
            U_CMOV:       sel_res = opb;
            default:      sel_res = '0;
        endcase
        raw_ovf = (ctrl.unit == U_MUL) ? mul_ovf : add_ovf;
        wr_c    = (ctrl.unit != U_NONE) && (in_rc_idx != ZERO_IDX)
                  && ((ctrl.unit != U_CMOV) || hit);
        ovf_c   = ctrl.trap_ok && in_func[TRAP_BIT] && raw_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q  <= '0;
            data_q <= '0;
            idx_q  <= '0;
        end else begin
            flg_q.valid <= in_valid;
            flg_q.wen   <= in_valid && wr_c;
            flg_q.ovf   <= in_valid && ovf_c;
            data_q      <= (in_valid && wr_c) ? sel_res : '0;
            idx_q       <= in_rc_idx;
        end
    end

    assign out_valid  = flg_q.valid;
    assign out_wen    = flg_q.wen;
    assign out_ovf    = flg_q.ovf;
    assign out_data   = data_q;
    assign out_rc_idx = idx_q;
endmodule

// File: rtl/int_op_unit_chk.sv
module int_op_unit_chk #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5,
    parameter int LIT_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [ieu_pkg::OPC_W-1:0] in_opcode,
    input logic                      chk_trap,
    input logic [3:0]                chk_sub,
    input logic [RIDX_W-1:0]         in_rb_idx,
    input logic [XLEN-1:0]           in_rb_val,
    input logic                      in_lit_sel,
    input logic [LIT_W-1:0]          in_lit,
    input logic [RIDX_W-1:0]         in_rc_idx,
    input logic                      out_valid,
    input logic [XLEN-1:0]           out_data,
    input logic                      out_wen,
    input logic                      out_ovf
);
    import ieu_pkg::*;
    localparam int HW = XLEN / 2;
    localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

    logic [XLEN-1:0] b_seen;
    logic            lw_op;

    always_comb begin
        if (in_lit_sel)
            b_seen = {{(XLEN-LIT_W){1'b0}}, in_lit};
        else if (in_rb_idx == ZERO_IDX)
            b_seen = '0;
        else
            b_seen = in_rb_val;
        lw_op = ((in_opcode == OPC_MUL) && (chk_sub == 4'd1))
             || ((in_opcode == OPC_ARITH) && ((chk_sub == 4'd2) || (chk_sub == 4'd3)));
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && !out_wen && !out_ovf));

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wen && !out_ovf));

    // R12
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_rc_idx == ZERO_IDX)) |=> !out_wen);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !chk_trap) |=> !out_ovf);

    // R2
    canon_lw_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lw_op) |=> (out_data[XLEN-1:HW] == {HW{out_data[HW-1]}}));

    // R11
    cmov_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_wen && ($past(in_opcode) == OPC_CMOV)) |-> (out_data == $past(b_seen)));

    // R12
    wen_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> out_valid);
endmodule

bind int_op_unit int_op_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LIT_W(LIT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_opcode (in_opcode),
    .chk_trap  (in_func[ieu_pkg::TRAP_BIT]),
    .chk_sub   (in_func[3:0]),
    .in_rb_idx (in_rb_idx),
    .in_rb_val (in_rb_val),
    .in_lit_sel(in_lit_sel),
    .in_lit    (in_lit),
    .in_rc_idx (in_rc_idx),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_wen   (out_wen),
    .out_ovf   (out_ovf)
);

// File: tb/int_op_unit_test.sv
module int_op_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_opcode = '0;
    logic [10:0] in_func = '0;
    logic [4:0]  in_ra_idx = '0;
    logic [63:0] in_ra_val = '0;
    logic [4:0]  in_rb_idx = '0;
    logic [63:0] in_rb_val = '0;
    logic        in_lit_sel = 1'b0;
    logic [7:0]  in_lit = '0;
    logic [4:0]  in_rc_idx = '0;
    logic        out_valid;
    logic [4:0]  out_rc_idx;
    logic [63:0] out_data;
    logic        out_wen;
    logic        out_ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int_op_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_func(in_func), .in_ra_idx(in_ra_idx), .in_ra_val(in_ra_val),
        .in_rb_idx(in_rb_idx), .in_rb_val(in_rb_val), .in_lit_sel(in_lit_sel),
        .in_lit(in_lit), .in_rc_idx(in_rc_idx), .out_valid(out_valid),
        .out_rc_idx(out_rc_idx), .out_data(out_data), .out_wen(out_wen),
        .out_ovf(out_ovf)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] sx32(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    // Returns {wen, ovf, data}
    function automatic logic [65:0] model(input logic [5:0] opc, input logic [3:0] s,
                                          input logic trap, input logic [63:0] a,
                                          input logic [63:0] b);
        logic        w, o, c;
        logic [63:0] d, r, sh;
        logic [64:0] t;
        logic [127:0] p;
        logic [2:0]  k;
        w = 1'b1; o = 1'b0; d = '0;
        k = 3'(s - 4'd4);
        case (opc)
            6'h08: begin
                if (s < 4 && !s[1]) begin
                    t = s[0] ? ({a[63], a} - {b[63], b}) : ({a[63], a} + {b[63], b});
                    d = t[63:0];
                    o = trap && (t[64] != t[63]);
                end else if (s < 4) begin
                    r = s[0] ? (sx32(a) - sx32(b)) : (sx32(a) + sx32(b));
                    d = sx32(r);
                    o = trap && (r != sx32(r));
                end else if (s < 12) begin
                    sh = k[0] ? (a << 3) : (a << 2);
                    r  = k[1] ? (sh - b) : (sh + b);
                    d  = k[2] ? sx32(r) : r;
                end else begin
                    case (s)
                        4'd12:   c = (a == b);
                        4'd13:   c = ($signed(a) < $signed(b));
                        4'd14:   c = ($signed(a) <= $signed(b));
                        default: c = (a < b);
                    endcase
                    d = {63'd0, c};
                end
            end
            6'h09: begin
                case (s)
                    4'd0: d = a & b;
                    4'd1: d = a & ~b;
                    4'd2: d = a | b;
                    4'd3: d = a | ~b;
                    4'd4: d = a ^ b;
                    4'd5: d = ~(a ^ b);
                    default: w = 1'b0;
                endcase
            end
            6'h0A: begin
                case (s)
                    4'd0: d = a << b[5:0];
                    4'd1: d = a >> b[5:0];
                    4'd2: d = $unsigned($signed(a) >>> b[5:0]);
                    default: w = 1'b0;
                endcase
            end
            6'h0B: begin
                if (s == 4'd0) begin
                    p = {{64{a[63]}}, a} * {{64{b[63]}}, b};
                    d = p[63:0];
                    o = trap && (p != {{64{p[63]}}, p[63:0]});
                end else if (s == 4'd1) begin
                    r = sx32(a) * sx32(b);
                    d = sx32(r);
                    o = trap && (r != sx32(r));
                end else w = 1'b0;
            end
            6'h0C: begin
                if (s[3]) w = 1'b0;
                else begin
                    case (s[2:0])
                        3'd0: c = (a == 0);
                        3'd1: c = (a != 0);
                        3'd2: c = a[63];
                        3'd3: c = !a[63];
                        3'd4: c = a[63] || (a == 0);
                        3'd5: c = !a[63] && (a != 0);
                        3'd6: c = a[0];
                        default: c = !a[0];
                    endcase
                    w = c;
                    d = b;
                end
            end
            default: w = 1'b0;
        endcase
        if (!w) d = '0;
        return {w, o, d};
    endfunction

    function automatic string req_of(input logic [5:0] opc, input logic [3:0] s);
        case (opc)
            6'h08: return (s < 2) ? "R1" : (s < 4) ? "R2" : (s < 12) ? "R6" : "R7";
            6'h09: return "R8";
            6'h0A: return "R9";
            6'h0B: return (s == 1) ? "R2" : "R10";
            6'h0C: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic run_op(input logic [5:0] opc, input logic [10:0] func,
                          input logic [4:0] ra_i, input logic [63:0] ra_v,
                          input logic [4:0] rb_i, input logic [63:0] rb_v,
                          input logic lsel, input logic [7:0] lit, input logic [4:0] rc,
                          input logic [65:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opc; in_func = func;
        in_ra_idx = ra_i; in_ra_val = ra_v; in_rb_idx = rb_i; in_rb_val = rb_v;
        in_lit_sel = lsel; in_lit = lit; in_rc_idx = rc;
        @(negedge clk);
        in_valid = 1'b0;
        n_run++;
        if (out_valid !== 1'b1 || out_wen !== exp[65] || out_ovf !== exp[64]
            || out_data !== exp[63:0] || out_rc_idx !== rc) begin
            n_fail++;
            $display("FAIL %s op=%h func=%h a=%h b=%h: actual v=%b w=%b o=%b d=%h expected v=1 w=%b o=%b d=%h",
                     tag, opc, func, ra_v, rb_v, out_valid, out_wen, out_ovf, out_data,
                     exp[65], exp[64], exp[63:0]);
        end
    endtask

    logic [63:0] vals [10];

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        vals[0] = 64'h0;
        vals[1] = 64'h1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[4] = 64'h8000_0000_0000_0000;
        vals[5] = 64'h0000_0000_7FFF_FFFF;
        vals[6] = 64'h0000_0000_8000_0000;
        vals[7] = 64'hFFFF_FFFF_8000_0000;
        vals[8] = 64'h0000_0001_0000_0003;
        vals[9] = 64'h1234_5678_9ABC_DEF0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_ovf !== 1'b0 || out_data !== 64'h0) begin
            n_fail++;
            $display("FAIL R12 reset: actual v=%b w=%b o=%b d=%h expected all zero",
                     out_valid, out_wen, out_ovf, out_data);
        end
        rst = 1'b0;

        // Sweep: R1 R2 R3 R6 R7 R8 R9 R10 R11 R12 (unused sub-ops)
        for (int oi = 0; oi < 5; oi++) begin
            for (int s = 0; s < 16; s++) begin
                for (int tr = 0; tr < 2; tr++) begin
                    for (int ia = 0; ia < 10; ia++) begin
                        for (int ib = 0; ib < 10; ib++) begin
                            logic [5:0] opc;
                            opc = 6'(8 + oi);
                            run_op(opc, {tr[0], 6'd0, s[3:0]}, 5'd1, vals[ia], 5'd2, vals[ib],
                                   1'b0, 8'h00, 5'd3,
                                   model(opc, s[3:0], tr[0], vals[ia], vals[ib]),
                                   tr[0] ? {req_of(opc, s[3:0]), "/R3"} : req_of(opc, s[3:0]));
                        end
                    end
                end
            end
        end

        // R4: literal replaces rb value, zero-extended
        run_op(6'h08, 11'h000, 5'd1, 64'd5, 5'd2, 64'hDEAD_BEEF_0000_0000, 1'b1, 8'hF0, 5'd4,
               {2'b10, 64'h0000_0000_0000_00F5}, "R4");
        run_op(6'h08, 11'h001, 5'd1, 64'd0, 5'd2, 64'h1, 1'b1, 8'hFF, 5'd4,
               {2'b10, 64'hFFFF_FFFF_FFFF_FF01}, "R4");
        // R5: index 31 reads zero
        run_op(6'h08, 11'h000, 5'd31, 64'h1111_2222_3333_4444, 5'd2, 64'd7, 1'b0, 8'h00, 5'd5,
               {2'b10, 64'd7}, "R5");
        run_op(6'h09, 11'h002, 5'd1, 64'h00F0, 5'd31, 64'hFFFF_0000_FFFF_0000, 1'b0, 8'h00, 5'd5,
               {2'b10, 64'h00F0}, "R5");
        run_op(6'h0C, 11'h000, 5'd31, 64'h99, 5'd2, 64'hABCD, 1'b0, 8'h00, 5'd6,
               {2'b10, 64'hABCD}, "R5");
        // R12: destination 31, unknown opcode
        run_op(6'h08, 11'h000, 5'd1, 64'd3, 5'd2, 64'd4, 1'b0, 8'h00, 5'd31,
               {2'b00, 64'd0}, "R12");
        run_op(6'h3F, 11'h000, 5'd1, 64'd3, 5'd2, 64'd4, 1'b0, 8'h00, 5'd7,
               {2'b00, 64'd0}, "R12");
        // R3: overflow flagged even when destination is 31
        run_op(6'h08, 11'h400, 5'd1, 64'h7FFF_FFFF_FFFF_FFFF, 5'd2, 64'd1, 1'b0, 8'h00, 5'd31,
               {2'b01, 64'd0}, "R3");
        // R12: idle cycle
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 idle: actual v=%b w=%b o=%b expected v=0 w=0 o=0",
                     out_valid, out_wen, out_ovf);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule